// File: doc/BRIEF.md
# H-Bridge PWM Drive Sequencer

This block drives the three logic inputs of a full H-bridge power stage: a modulation enable (`pwm_o`), a polarity select (`dir_o`) and a brake line (`brake_o`). It takes a signed duty command and can encode it in one of two ways. In anti-phase encoding the polarity line carries the whole modulated waveform and a half duty gives zero net drive. In sign/magnitude encoding the polarity line carries the sign and the enable line carries pulses whose width follows the magnitude. A brake request shorts the motor windings. An active-low thermal warning moves the bridge to the state in which all drivers are off.

The command, encoding select and brake request are taken in once per modulation period, so a period is never cut short. Every output edge passes through a spacing stage. That stage lets at most one of the three lines move in a cycle, and it holds back any edge that would come less than `GUARD` clock cycles after the previous edge on any line. With the default 50 MHz clock this guard is 1 µs. The period is 2^(CMD_W-1) cycles, which is 1024 with the default 11-bit command.

Top module: `hb_drive_seq`

## Requirements
- R1: While `rst` is high, and after any reset, the outputs hold the drivers-off state: `brake_o`=1, `pwm_o`=0, `dir_o`=0. They stay there until the first period boundary after reset.
- R2: The position counter runs from 0 to PERIOD-1 with PERIOD = 2^(CMD_W-1). `cmd_i`, `mode_sm_i` and `brake_req_i` are sampled only in the cycle where the position is PERIOD-1, and the sampled values apply to the whole next period. Changes at any other time have no effect until that boundary.
- R3: With `mode_sm_i`=0 (anti-phase), the target state is `brake_o`=0 and `pwm_o`=1. `dir_o` is high for the first floor((cmd+PERIOD)/2) positions of each period and low for the rest, so cmd 0 gives PERIOD/2 high cycles.
- R4: With `mode_sm_i`=1 (sign/magnitude), the target state is `brake_o`=0. `dir_o` is 1 when cmd is 0 or positive and 0 when cmd is negative. `pwm_o` is high for the first min(|cmd|, PERIOD-1) positions of each period.
- R5: In sign/magnitude encoding with cmd 0, `pwm_o` stays low for the whole period and produces no pulse.
- R6: A sampled brake request gives the target state `brake_o`=1, `pwm_o`=1, with `dir_o` kept at its present level.
- R7: `therm_n_i` low, seen through a SYNC_STAGES-flop synchronizer, gives the target state `brake_o`=1, `pwm_o`=0, with `dir_o` kept at its present level. The block stays in this fault state until `therm_n_i` is high again and a period boundary samples a new command.
- R8: At most one output changes in any clock cycle. When several outputs differ from their targets, `brake_o` moves first, then `pwm_o`, then `dir_o`.
- R9: Two output changes are always at least GUARD cycles apart. A pending change is made at the first clock edge where the guard has run out, so a sign/magnitude pulse shorter than GUARD is stretched to GUARD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | CMD_W | Signed drive command, two's complement |
| mode_sm_i | input | 1 | 0 selects anti-phase encoding, 1 selects sign/magnitude encoding |
| brake_req_i | input | 1 | Brake request |
| therm_n_i | input | 1 | Thermal warning, active low, asynchronous |
| pwm_o | output | 1 | Bridge modulation enable |
| dir_o | output | 1 | Bridge polarity select |
| brake_o | output | 1 | Bridge brake line |

## Verification
The hardest situation to reach is one where several outputs must move at once while an earlier edge is still inside its guard window. In that case both the priority order and the deferral apply together. The stimulus reaches it by sending the bridge into the thermal fault and the brake state from running waveforms, and by using a short sign/magnitude pulse and a near-full negative command. In those cases a target edge falls inside the guard window just after the previous edge. A behavioural reference model predicts every output on every cycle, so each deferred edge is checked at the exact cycle it should appear.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic {
    MODE_ANTI    = 1'b0,
    MODE_SIGNMAG = 1'b1
  } mod_mode_e;

  // Bit order matters: brake has the highest priority in the spacer.
  typedef struct packed {
    logic brake;
    logic pwm;
    logic dir;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{brake: 1'b1, pwm: 1'b0, dir: 1'b0};
endpackage

// File: rtl/hb_period_timer.sv
`timescale 1ns/1ps
module hb_period_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= pos + 1'b1;
  end

  // Last position of the period: the command is sampled here.
  assign wrap = &pos;
endmodule

// File: rtl/hb_thermal_guard.sv
`timescale 1ns/1ps
module hb_thermal_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic therm_n_i,
  input  logic wrap,
  output logic fault
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   warn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= therm_n_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign warn_s = ~sync_q[SYNC_STAGES-1];

  // Reset starts in fault so the first period keeps the drivers off.
  always_ff @(posedge clk) begin
    if (rst)         fault <= 1'b1;
    else if (warn_s) fault <= 1'b1;
    else if (wrap)   fault <= 1'b0;
  end

  // R7: the fault is only released at a period boundary
  a_r7_release_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (fault && !wrap) |=> fault);
endmodule

// File: rtl/hb_cmd_shaper.sv
`timescale 1ns/1ps
module hb_cmd_shaper
  import hb_pkg::*;
#(
  parameter int CMD_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wrap,
  input  logic [CMD_W-2:0]        pos,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  logic                    mode_i,
  input  logic                    brk_i,
  input  logic                    fault,
  input  logic                    cur_dir,
  output drive_t                  target,
  output logic signed [CMD_W-1:0] cmd_q,
  output mod_mode_e               mode_q,
  output logic                    brk_q
);
  localparam int CNT_W = CMD_W - 1;

  logic [CMD_W-1:0] offs;
  logic [CMD_W-1:0] neg;
  logic [CNT_W-1:0] ap_thr;
  logic [CNT_W-1:0] sm_mag;

  // Sample once per period, on its last position.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      mode_q <= MODE_ANTI;
      brk_q  <= 1'b0;
    end else if (wrap) begin
      cmd_q  <= cmd_i;
      mode_q <= mod_mode_e'(mode_i);
      brk_q  <= brk_i;
    end
  end

  // Anti-phase threshold: offset-binary command halved.
  assign offs   = {~cmd_q[CMD_W-1], cmd_q[CMD_W-2:0]};
  assign ap_thr = offs[CMD_W-1:1];

  // Sign/magnitude: absolute value saturated to PERIOD-1.
  assign neg    = -cmd_q;
  assign sm_mag = !cmd_q[CMD_W-1] ? cmd_q[CNT_W-1:0] :
                  (neg[CMD_W-1] ? {CNT_W{1'b1}} : neg[CNT_W-1:0]);

  always_comb begin
    target = DRIVE_OFF;
    if (fault) begin
      target = '{brake: 1'b1, pwm: 1'b0, dir: cur_dir};
    end else if (brk_q) begin
      target = '{brake: 1'b1, pwm: 1'b1, dir: cur_dir};
    end else if (mode_q == MODE_ANTI) begin
      target = '{brake: 1'b0, pwm: 1'b1, dir: (pos < ap_thr)};
    end else begin
      target = '{brake: 1'b0, pwm: (pos < sm_mag), dir: ~cmd_q[CMD_W-1]};
    end
  end

  // R2: the sampled command never moves inside a period
  a_r2_hold_in_period: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable({cmd_q, mode_q, brk_q}));
endmodule

// File: rtl/hb_edge_spacer.sv
`timescale 1ns/1ps
module hb_edge_spacer
  import hb_pkg::*;
#(
  parameter int GUARD = 50
) (
  input  logic   clk,
  input  logic   rst,
  input  drive_t target,
  output drive_t out_q
);
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [GW-1:0] GUARD_V = GW'(GUARD);

  logic [GW-1:0] gap_q;
  logic [2:0]    diff;
  logic          step;
  drive_t        nxt;

  assign diff = target ^ out_q;

  // One edge at a time, brake before pwm before dir.
  always_comb begin
    nxt  = out_q;
    step = 1'b0;
    if (gap_q == GUARD_V) begin
      if (diff[2]) begin
        nxt.brake = target.brake;
        step      = 1'b1;
      end else if (diff[1]) begin
        nxt.pwm = target.pwm;
        step    = 1'b1;
      end else if (diff[0]) begin
        nxt.dir = target.dir;
        step    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= DRIVE_OFF;
      gap_q <= GUARD_V;
    end else begin
      out_q <= nxt;
      if (step)                 gap_q <= GW'(1);
      else if (gap_q != GUARD_V) gap_q <= gap_q + 1'b1;
    end
  end

  // Independent observer of the spacing at the register output.
  drive_t        prev_q;
  logic [GW-1:0] seen_gap;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= DRIVE_OFF;
      seen_gap <= GUARD_V;
    end else begin
      prev_q <= out_q;
      if (out_q != prev_q)          seen_gap <= GW'(1);
      else if (seen_gap != GUARD_V) seen_gap <= seen_gap + 1'b1;
    end
  end

  // R1: reset forces the drivers-off state
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> (out_q == DRIVE_OFF));
  // R8: never more than one output moves per cycle
  a_r8_single_edge: assert property (@(posedge clk) disable iff (rst)
    $countones(out_q ^ prev_q) <= 1);
  // R9: output changes are at least GUARD cycles apart
  a_r9_guard_gap: assert property (@(posedge clk) disable iff (rst)
    (out_q != prev_q) |-> (seen_gap >= GUARD_V));
endmodule

// File: rtl/hb_drive_seq.sv
`timescale 1ns/1ps
module hb_drive_seq
  import hb_pkg::*;
#(
  parameter int CMD_W       = 11,
  parameter int GUARD       = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  logic                    mode_sm_i,
  input  logic                    brake_req_i,
  input  logic                    therm_n_i,
  output logic                    pwm_o,
  output logic                    dir_o,
  output logic                    brake_o
);
  localparam int CNT_W = CMD_W - 1;

  logic [CNT_W-1:0]        pos;
  logic                    wrap;
  logic                    fault;
  drive_t                  target;
  drive_t                  drv;
  logic signed [CMD_W-1:0] cmd_q;
  mod_mode_e               mode_q;
  logic                    brk_q;

  hb_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .pos(pos), .wrap(wrap)
  );

  hb_thermal_guard #(.SYNC_STAGES(SYNC_STAGES)) u_therm (
    .clk(clk), .rst(rst), .therm_n_i(therm_n_i), .wrap(wrap), .fault(fault)
  );

  hb_cmd_shaper #(.CMD_W(CMD_W)) u_shaper (
    .clk(clk), .rst(rst), .wrap(wrap), .pos(pos),
    .cmd_i(cmd_i), .mode_i(mode_sm_i), .brk_i(brake_req_i),
    .fault(fault), .cur_dir(drv.dir), .target(target),
    .cmd_q(cmd_q), .mode_q(mode_q), .brk_q(brk_q)
  );

  hb_edge_spacer #(.GUARD(GUARD)) u_spacer (
    .clk(clk), .rst(rst), .target(target), .out_q(drv)
  );

  assign pwm_o   = drv.pwm;
  assign dir_o   = drv.dir;
  assign brake_o = drv.brake;

  // R7: no enable pulse can start while the thermal fault is active
  a_r7_no_pwm_in_fault: assert property (@(posedge clk) disable iff (rst)
    fault |=> !$rose(pwm_o));
  // R5: zero sign/magnitude command gives no pulse
  a_r5_sm_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SIGNMAG && cmd_q == '0 && !brk_q && !fault) |=> !$rose(pwm_o));
  // R3: anti-phase keeps the enable line high
  a_r3_anti_pwm_high: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ANTI && !brk_q && !fault && pwm_o) |=> pwm_o);
  // R6: a braking bridge keeps the brake line high
  a_r6_brake_held: assert property (@(posedge clk) disable iff (rst)
    (brk_q && !fault && brake_o) |=> brake_o);
endmodule

// File: tb/hb_drive_seq_bench.sv
`timescale 1ns/1ps
module hb_drive_seq_bench;
  localparam int CMD_W = 11;
  localparam int GUARD = 50;
  localparam int SYNC  = 2;
  localparam int PER   = 1 << (CMD_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [CMD_W-1:0] cmd = '0;
  logic mode = 1'b0, brk = 1'b0, therm_n = 1'b1;
  logic pwm, dir, brake;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hb_drive_seq #(.CMD_W(CMD_W), .GUARD(GUARD), .SYNC_STAGES(SYNC)) u_hb_drive_seq (
    .clk(clk), .rst(rst), .cmd_i(cmd), .mode_sm_i(mode), .brake_req_i(brk),
    .therm_n_i(therm_n), .pwm_o(pwm), .dir_o(dir), .brake_o(brake)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_cmd, m_mode, m_brk, m_fault, m_since, m_thr, m_mag;
  bit m_b, m_p, m_d, t_b, t_p, t_d, m_ts;
  bit sq[$];
  bit started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_cnt = 0; m_cmd = 0; m_mode = 0; m_brk = 0; m_fault = 1;
      m_b = 1; m_p = 0; m_d = 0; m_since = GUARD;
      sq.delete();
      for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
    end else begin
      if (m_fault != 0) begin
        t_b = 1; t_p = 0; t_d = m_d;
      end else if (m_brk != 0) begin
        t_b = 1; t_p = 1; t_d = m_d;
      end else if (m_mode == 0) begin
        m_thr = (m_cmd + PER) / 2;
        t_b = 0; t_p = 1; t_d = (m_cnt < m_thr);
      end else begin
        m_mag = (m_cmd < 0) ? -m_cmd : m_cmd;
        if (m_mag > PER - 1) m_mag = PER - 1;
        t_b = 0; t_p = (m_cnt < m_mag); t_d = (m_cmd >= 0);
      end
      if (m_since >= GUARD && (t_b != m_b || t_p != m_p || t_d != m_d)) begin
        if (t_b != m_b)      m_b = t_b;
        else if (t_p != m_p) m_p = t_p;
        else                 m_d = t_d;
        m_since = 1;
      end else if (m_since < GUARD) begin
        m_since++;
      end
      m_ts = sq.pop_front();
      sq.push_back(therm_n);
      if (!m_ts) m_fault = 1;
      else if (m_cnt == PER - 1) m_fault = 0;
      if (m_cnt == PER - 1) begin
        m_cmd = int'(cmd); m_mode = mode; m_brk = brk;
      end
      m_cnt = (m_cnt + 1) % PER;
    end
  end

  // R2 plus every encoding: full output comparison each cycle
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if ({brake, pwm, dir} !== {m_b, m_p, m_d}) begin
        errors++;
        $display("FAIL R2 cycle model at %0t actual=%b%b%b expected=%b%b%b (brake,pwm,dir)",
                 $time, brake, pwm, dir, m_b, m_p, m_d);
      end
    end
  end

  // R8 / R9 edge monitor at the ports
  logic [2:0] mon_prev = 3'b100;
  int mon_gap = GUARD;
  always @(negedge clk) begin
    if (rst) begin
      mon_prev = {brake, pwm, dir};
      mon_gap  = GUARD;
    end else if (started) begin
      if ({brake, pwm, dir} != mon_prev) begin
        check("R8 one output per edge", $countones({brake, pwm, dir} ^ mon_prev), 1);
        checks++;
        if (mon_gap < GUARD) begin
          errors++;
          $display("FAIL R9 edge gap actual=%0d expected>=%0d", mon_gap, GUARD);
        end
        mon_gap = 1;
      end else if (mon_gap < GUARD) begin
        mon_gap++;
      end
      mon_prev = {brake, pwm, dir};
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int np, output int nd, output int nb);
    np = 0; nd = 0; nb = 0;
    repeat (PER) begin
      @(negedge clk);
      #1;
      np += int'(pwm); nd += int'(dir); nb += int'(brake);
    end
  endtask

  task automatic apply(bit m, int c, bit b);
    @(negedge clk);
    mode = m; cmd = CMD_W'(c); brk = b;
    wait_cyc(3 * PER);
  endtask

  initial begin
    int np, nd, nb;
    wait_cyc(5);
    #1;
    check("R1 brake in reset", int'(brake), 1);
    check("R1 pwm in reset",   int'(pwm),   0);
    check("R1 dir in reset",   int'(dir),   0);
    @(negedge clk) rst = 1'b0;
    wait_cyc(20);
    #1;
    check("R1 off after reset", int'({brake, pwm, dir}), 3'b100);

    apply(0, 0, 0);
    measure(np, nd, nb);
    check("R3 anti zero dir high", nd, PER / 2);
    check("R3 anti pwm high", np, PER);
    check("R3 anti brake low", nb, 0);

    apply(0, 511, 0);
    measure(np, nd, nb);
    check("R3 anti +511 dir high", nd, 767);

    apply(0, -1024, 0);
    measure(np, nd, nb);
    check("R3 anti full negative dir high", nd, 0);

    apply(1, 300, 0);
    measure(np, nd, nb);
    check("R4 sm +300 pwm high", np, 300);
    check("R4 sm +300 dir", nd, PER);

    apply(1, -300, 0);
    measure(np, nd, nb);
    check("R4 sm -300 pwm high", np, 300);
    check("R4 sm -300 dir", nd, 0);

    apply(1, 0, 0);
    measure(np, nd, nb);
    check("R5 sm zero pwm high", np, 0);

    apply(1, 10, 0);
    measure(np, nd, nb);
    check("R9 short pulse stretched", np, GUARD);

    apply(1, -1024, 0);
    apply(1, 300, 0);
    apply(1, 300, 1);
    measure(np, nd, nb);
    check("R6 brake line", nb, PER);
    check("R6 pwm during brake", np, PER);
    check("R6 dir kept", nd, PER);

    apply(0, 0, 0);
    // mid-period change: only the model comparison sees its timing (R2)
    wait_cyc(300);
    @(negedge clk) cmd = CMD_W'(200);
    wait_cyc(3 * PER);

    @(negedge clk) therm_n = 1'b0;
    wait_cyc(200);
    measure(np, nd, nb);
    check("R7 fault brake", nb, PER);
    check("R7 fault pwm", np, 0);
    @(negedge clk) therm_n = 1'b1;
    wait_cyc(3 * PER);
    measure(np, nd, nb);
    check("R7 resumed brake", nb, 0);
    check("R7 resumed pwm", np, PER);

    // single-cycle warning pulse still latches until a boundary
    @(negedge clk) therm_n = 1'b0;
    @(negedge clk) therm_n = 1'b1;
    wait_cyc(3 * PER);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule